// File: doc/BRIEF.md
# QPSK Symbol Mapper and Hard-Decision Demapper

This block sits between a rate-1/2 channel coder and a 16-bit complex channel. In the transmit direction it takes one 2-bit coded symbol per valid cycle. It turns that symbol into one complex sample: a signed 8-bit in-phase part and a signed 8-bit quadrature part. Each part carries a level of plus or minus one, written as a 7-bit signed value of magnitude 32. The eighth bit and the unused magnitude leave room for channel noise to add to the level without the value wrapping.

In the receive direction it takes one noisy 16-bit sample per valid cycle and decides each part on its sign alone. Both lanes register their result and the matching valid flag, so each has a latency of one cycle. When no valid input arrives, a lane keeps its previous output.

Top module: `qpsk_symbol_codec`

## Requirements
- R1: During reset, both valid outputs are 0, the sample output is 16'h0000 and the symbol output is 2'b00.
- R2: mapValidOut equals mapValidIn from the previous clock cycle.
- R3: One cycle after a valid symbol, mapSampleOut[15:8] (in-phase) is 8'h20 (+32) when symbol bit 1 is 0, and 8'hE0 (−32) when symbol bit 1 is 1.
- R4: One cycle after a valid symbol, mapSampleOut[7:0] (quadrature) is 8'h20 when symbol bit 0 is 0, and 8'hE0 when symbol bit 0 is 1.
- R5: Every valid mapped component fits in 7 signed bits: bits 7 and 6 of each byte are equal.
- R6: demapValidOut equals demapValidIn from the previous clock cycle.
- R7: One cycle after a valid sample, demapSymOut[1] is 1 exactly when the in-phase byte is negative as a two's complement value. demapSymOut[0] is 1 exactly when the quadrature byte is negative.
- R8: A component equal to exactly zero decodes as bit 0.
- R9: The extreme components decode by sign without wrapping: 8'h80 (−128) gives 1 and 8'h7F (+127) gives 0.
- R10: While a lane's valid input is low, its data output holds its previous value, whatever that lane's data input does.
- R11: Feeding the mapper output into the demapper returns each original symbol, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapValidIn | input | 1 | Symbol input is valid |
| mapSymIn | input | 2 | Coded symbol; bit 1 sets in-phase, bit 0 sets quadrature |
| mapValidOut | output | 1 | Sample output is valid |
| mapSampleOut | output | 16 | {in-phase[7:0], quadrature[7:0]} signed levels |
| demapValidIn | input | 1 | Channel sample input is valid |
| demapSampleIn | input | 16 | Noisy {in-phase, quadrature} sample |
| demapValidOut | output | 1 | Symbol output is valid |
| demapSymOut | output | 2 | Hard-decided symbol |

## Verification
On every cycle the assertions check four things: the one-cycle valid timing of both lanes, the mapped levels for the previous symbol, the 7-bit fit of those levels, and the output hold during idle cycles. They also check that the demapped bits match the sign bits of the previous sample. Some cases need stimulus that the bench chooses: exact zero, the −128 and +127 extremes, the small noisy values near zero, and the in-order recovery of symbols through the loopback.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  localparam int COMP_W    = 8;
  localparam int LEVEL_W   = 7;
  localparam int LEVEL_MAG = 32;
  localparam int SYM_W     = 2;
  localparam int SAMPLE_W  = 2 * COMP_W;
  localparam int LUT_N     = 1 << SYM_W;

  typedef struct packed {
    logic mapLoad;
    logic demapLoad;
  } qpsk_strobe_t;
endpackage

// File: rtl/qpsk_ctrl.sv
module qpsk_ctrl
  import qpsk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         mapValidIn,
  input  logic         demapValidIn,
  output qpsk_strobe_t strobe,
  output logic         mapValidOut,
  output logic         demapValidOut
);
  // Load strobes follow the incoming valid flags directly.
  always_comb begin
    strobe.mapLoad   = mapValidIn;
    strobe.demapLoad = demapValidIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapValidOut   <= 1'b0;
      demapValidOut <= 1'b0;
    end else begin
      mapValidOut   <= mapValidIn;
      demapValidOut <= demapValidIn;
    end
  end
endmodule

// File: rtl/qpsk_map_dp.sv
module qpsk_map_dp
  import qpsk_pkg::*;
#(
  parameter int CompW    = COMP_W,
  parameter int LevelW   = LEVEL_W,
  parameter int LevelMag = LEVEL_MAG
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [1:0]         symIn,
  output logic [2*CompW-1:0] sampleOut
);
  localparam int SampleW = 2 * CompW;
  localparam logic signed [CompW-1:0] PosLevel = CompW'(LevelMag);
  localparam logic signed [CompW-1:0] NegLevel = -PosLevel;

  // A bit of 0 gives +1, and a bit of 1 gives -1.
  function automatic logic [CompW-1:0] levelOf(input logic b);
    return b ? NegLevel : PosLevel;
  endfunction

  logic [SampleW-1:0] lut [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    localparam logic [1:0] Idx = 2'(g);
    assign lut[g] = {levelOf(Idx[1]), levelOf(Idx[0])};
  end

  always_ff @(posedge clk) begin
    if (!rstN)     sampleOut <= '0;
    else if (load) sampleOut <= lut[symIn];
  end
endmodule

// File: rtl/qpsk_demap_dp.sv
module qpsk_demap_dp
  import qpsk_pkg::*;
#(
  parameter int CompW = COMP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [2*CompW-1:0] sampleIn,
  output logic [1:0]         symOut
);
  localparam int SampleW = 2 * CompW;

  logic [1:0] signIdx;
  logic [1:0] decLut [LUT_N];

  // The index is the sign pair {in-phase, quadrature}. A zero part has a clear sign bit, so it decodes as 0.
  assign signIdx = {sampleIn[SampleW-1], sampleIn[CompW-1]};

  for (genvar g = 0; g < LUT_N; g++) begin : g_dec
    localparam logic [1:0] Idx = 2'(g);
    assign decLut[g] = {Idx[1], Idx[0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)     symOut <= '0;
    else if (load) symOut <= decLut[signIdx];
  end
endmodule

// File: rtl/qpsk_symbol_codec.sv
module qpsk_symbol_codec
  import qpsk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mapValidIn,
  input  logic [1:0]  mapSymIn,
  output logic        mapValidOut,
  output logic [15:0] mapSampleOut,
  input  logic        demapValidIn,
  input  logic [15:0] demapSampleIn,
  output logic        demapValidOut,
  output logic [1:0]  demapSymOut
);
  qpsk_strobe_t strobe;

  qpsk_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .mapValidIn   (mapValidIn),
    .demapValidIn (demapValidIn),
    .strobe       (strobe),
    .mapValidOut  (mapValidOut),
    .demapValidOut(demapValidOut)
  );

  qpsk_map_dp u_map (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobe.mapLoad),
    .symIn    (mapSymIn),
    .sampleOut(mapSampleOut)
  );

  qpsk_demap_dp u_demap (
    .clk     (clk),
    .rstN    (rstN),
    .load    (strobe.demapLoad),
    .sampleIn(demapSampleIn),
    .symOut  (demapSymOut)
  );
endmodule

// File: rtl/qpsk_symbol_codec_chk.sv
module qpsk_symbol_codec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mapValidIn,
  input logic [1:0]  mapSymIn,
  input logic        mapValidOut,
  input logic [15:0] mapSampleOut,
  input logic        demapValidIn,
  input logic [15:0] demapSampleIn,
  input logic        demapValidOut,
  input logic [1:0]  demapSymOut
);
  a_r2_map_valid: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> mapValidOut == $past(mapValidIn));

  a_r3_real_level: assert property (@(posedge clk) disable iff (!rstN)
    mapValidIn |=> mapSampleOut[15:8] == ($past(mapSymIn[1]) ? 8'hE0 : 8'h20));

  a_r4_imag_level: assert property (@(posedge clk) disable iff (!rstN)
    mapValidIn |=> mapSampleOut[7:0] == ($past(mapSymIn[0]) ? 8'hE0 : 8'h20));

  a_r5_fits_seven_bits: assert property (@(posedge clk) disable iff (!rstN)
    mapValidOut |-> (mapSampleOut[15] == mapSampleOut[14]) && (mapSampleOut[7] == mapSampleOut[6]));

  a_r6_demap_valid: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> demapValidOut == $past(demapValidIn));

  a_r7_sign_decision: assert property (@(posedge clk) disable iff (!rstN)
    demapValidIn |=> demapSymOut == {$past(demapSampleIn[15]), $past(demapSampleIn[7])});

  a_r10_map_hold: assert property (@(posedge clk) disable iff (!rstN)
    !mapValidIn |=> $stable(mapSampleOut));

  a_r10_demap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !demapValidIn |=> $stable(demapSymOut));
endmodule

bind qpsk_symbol_codec qpsk_symbol_codec_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .mapValidIn   (mapValidIn),
  .mapSymIn     (mapSymIn),
  .mapValidOut  (mapValidOut),
  .mapSampleOut (mapSampleOut),
  .demapValidIn (demapValidIn),
  .demapSampleIn(demapSampleIn),
  .demapValidOut(demapValidOut),
  .demapSymOut  (demapSymOut)
);

// File: tb/qpsk_symbol_codec_bench.sv
module qpsk_symbol_codec_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapValidIn = 1'b0;
  logic [1:0]  mapSymIn = '0;
  logic        mapValidOut;
  logic [15:0] mapSampleOut;
  logic        demapValidIn = 1'b0;
  logic [15:0] demapSampleIn = '0;
  logic        demapValidOut;
  logic [1:0]  demapSymOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit modelOn = 1'b0;
  bit loopOn = 1'b0;

  // Reference model state, updated behaviourally at each rising edge.
  logic        mValid = 1'b0, dValid = 1'b0;
  int          mRe = 0, mIm = 0;
  logic [1:0]  dSym = '0;
  logic [1:0]  sentQ[$];

  always #5 clk = ~clk;

  qpsk_symbol_codec u_qpsk_symbol_codec (
    .clk(clk), .rstN(rstN),
    .mapValidIn(mapValidIn), .mapSymIn(mapSymIn),
    .mapValidOut(mapValidOut), .mapSampleOut(mapSampleOut),
    .demapValidIn(demapValidIn), .demapSampleIn(demapSampleIn),
    .demapValidOut(demapValidOut), .demapSymOut(demapSymOut)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int toInt8(input logic [7:0] v);
    return (v >= 8'd128) ? int'(v) - 256 : int'(v);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mValid <= 1'b0; dValid <= 1'b0; mRe <= 0; mIm <= 0; dSym <= '0;
    end else begin
      mValid <= mapValidIn;
      dValid <= demapValidIn;
      if (mapValidIn) begin
        mRe <= mapSymIn[1] ? -32 : 32;
        mIm <= mapSymIn[0] ? -32 : 32;
      end
      if (demapValidIn)
        dSym <= {toInt8(demapSampleIn[15:8]) < 0, toInt8(demapSampleIn[7:0]) < 0};
    end
  end

  // Per-cycle comparison against the model on the falling edge.
  always @(negedge clk) begin
    if (modelOn) begin
      check("R2", int'(mapValidOut), int'(mValid));
      check("R3", toInt8(mapSampleOut[15:8]), mRe);
      check("R4", toInt8(mapSampleOut[7:0]), mIm);
      check("R6", int'(demapValidOut), int'(dValid));
      check("R7", int'(demapSymOut), int'(dSym));
      if (mapValidOut) begin
        check("R5", int'(mapSampleOut[15] == mapSampleOut[14]), 1);
        check("R5", int'(mapSampleOut[7] == mapSampleOut[6]), 1);
      end
      if (loopOn && demapValidOut) begin
        if (sentQ.size() == 0) check("R11", 1, 0);
        else check("R11", int'(demapSymOut), int'(sentQ.pop_front()));
      end
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 5000) begin
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
    finishRun();
  end

  task automatic demapOne(input logic [15:0] s, input string req, input int expSym);
    @(negedge clk); demapValidIn = 1'b1; demapSampleIn = s;
    @(negedge clk); demapValidIn = 1'b0; demapSampleIn = ~s;
    check(req, int'(demapSymOut), expSym);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", int'(mapValidOut), 0);
    check("R1", int'(demapValidOut), 0);
    check("R1", int'(mapSampleOut), 0);
    check("R1", int'(demapSymOut), 0);
    rstN = 1'b1; modelOn = 1'b1;

    // Mapper: all four symbols back to back, then with idle gaps
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); mapValidIn = 1'b1; mapSymIn = 2'(i);
    end
    @(negedge clk); mapValidIn = 1'b0; mapSymIn = 2'b11;
    @(negedge clk); mapSymIn = 2'b00;
    @(negedge clk);
    check("R10", int'(mapSampleOut), 16'hE0E0); // last valid symbol was 3
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk); mapValidIn = 1'b1; mapSymIn = 2'(i);
      @(negedge clk); mapValidIn = 1'b0; mapSymIn = 2'(~i);
    end
    check("R3", int'(mapSampleOut[15:8]), 8'h20);
    check("R4", int'(mapSampleOut[7:0]), 8'h20);

    // Demapper directed corner cases
    demapOne(16'h0000, "R8", 0);
    demapOne(16'h0020, "R8", 0);
    demapOne(16'h8000, "R9", 2);
    demapOne(16'h7F80, "R9", 1);
    demapOne(16'h807F, "R9", 2);
    demapOne(16'h05FB, "R7", 1);
    demapOne(16'hFF01, "R7", 2);
    demapOne(16'hE0E0, "R7", 3);
    @(negedge clk); demapSampleIn = 16'h8080;
    @(negedge clk);
    check("R10", int'(demapSymOut), 3);

    // Loopback: mapper output feeds the demapper
    loopOn = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      demapValidIn = mapValidOut; demapSampleIn = mapSampleOut;
      mapValidIn = (i % 3) != 2 && i < 20;
      mapSymIn = 2'((i * 7 + 1) % 4);
      if (mapValidIn) sentQ.push_back(mapSymIn);
    end
    @(negedge clk); demapValidIn = 1'b0; mapValidIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", sentQ.size(), 0);
    finishRun();
  end
endmodule